// File: doc/BRIEF.md
# Clock-Tree Frequency Calculator

This block works out, in Hz, the frequencies that a clock controller's settings produce. It reads three configuration words: a mode word, a post-divider word and a fractional-N PLL control word. From them it derives four values: the PLL reference, the core clock, the high-speed bus clock and the peripheral bus clock. A timer or a baud-rate block that needs to know its input frequency reads the results. The block does not generate any clock.

A one-cycle `start` pulse latches the three words. The block then runs a single shared restoring divider three times: once for the PLL ratio, once for the high-speed post-divider and once for the peripheral post-divider. When the run ends, all four outputs update on the same edge and `done` pulses for one cycle. A `start` that arrives during a run is remembered. Exactly one further run follows, and it uses the words present when that run begins.

A small selector output returns one of the clocks by code, a constant low-frequency value, or zero.

Top module: `clkfreq_calc`

## Requirements
- R1: After reset, `busy`, `done`, `ref_hz`, `core_hz`, `hs_hz` and `pb_hz` are all 0.
- R2: The reference is 33554432 Hz when mode bits [2:1] equal 2'b01. For every other value of those bits it is 26000000 Hz.
- R3: The PLL is bypassed when mode bit 7 is 1 or mode bit 3 is 0. While it is bypassed, `core_hz` equals the reference.
- R4: When the PLL is not bypassed, the PLL word fields are read as follows:
  - pd = bits [29:26] + 1
  - mfd = bits [25:16] + 1
  - mfi = bits [13:10]
  - mfn = bits [9:0], a signed two's-complement value

  The core clock is ((2·(ref>>10)·(mfi·mfd+mfn)) / (mfd·pd)) << 10. The division truncates.
- R5: An mfi field value below 5 gives the same result as the value 5.
- R6: When mfi·mfd+mfn is zero or negative and the PLL is not bypassed, `core_hz`, `hs_hz` and `pb_hz` are 0.
- R7: `hs_hz` = core / (1 + post-divider word bits [13:11]). `pb_hz` = `hs_hz` / (1 + bits [7:6]). Both divisions truncate.
- R8: The four frequency outputs change only on the edge that raises `done`. `done` lasts exactly one cycle. `busy` is high from the edge after `start` until the run ends.
- R9: A `start` received while busy, once or several times, causes exactly one more run. That run uses the input words present when it begins.
- R10: `sel_hz` returns a value chosen by `sel`:

  | `sel` | `sel_hz` |
  |---|---|
  | 1 | core |
  | 2 | high-speed |
  | 3 | peripheral |
  | 4 | 32768 |
  | 0 and other codes | 0 |

  `lf_hz` is always 32768.
- R11: The shifted PLL result is kept modulo 2^32 before the post-dividers see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a recompute |
| mode_word | input | 32 | Reference select and PLL enable/bypass bits |
| div_word | input | 32 | Post-divider fields |
| pll_word | input | 32 | PLL pre-divider, denominator, integer and numerator fields |
| sel | input | 3 | Clock selector code |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when results update |
| ref_hz | output | 32 | PLL reference frequency |
| core_hz | output | 32 | Core clock frequency |
| hs_hz | output | 32 | High-speed bus clock frequency |
| pb_hz | output | 32 | Peripheral bus clock frequency |
| lf_hz | output | 32 | Fixed low-frequency clock value |
| sel_hz | output | 32 | Frequency chosen by `sel` |

## Verification
Some properties are checked by assertions on every cycle:
- the four outputs never move except on the `done` edge,
- `done` never lasts two cycles,
- a `start` is always followed by `busy`,
- every published result has peripheral ≤ high-speed ≤ core and a legal reference.

The arithmetic itself can only be shown by the bench's scenarios, which compare against values computed independently. These scenarios cover both reference choices, both bypass causes, the clamped integer field, a negative numerator, a non-positive term and 32-bit wraparound. The bench scenarios are also the only evidence for the queued-start count and for the inputs that a queued run picks up.

// File: rtl/clkfreq_calc.sv
module clkfreq_calc #(
  parameter int W      = 32,
  parameter int PW     = 48,
  parameter int DW     = 16,
  parameter int REF_HI = 26000000,
  parameter int REF_LO = 33554432,
  parameter int LF_HZ  = 32768
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] mode_word,
  input  logic [W-1:0] div_word,
  input  logic [W-1:0] pll_word,
  input  logic [2:0]   sel,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] ref_hz,
  output logic [W-1:0] core_hz,
  output logic [W-1:0] hs_hz,
  output logic [W-1:0] pb_hz,
  output logic [W-1:0] lf_hz,
  output logic [W-1:0] sel_hz
);
  localparam int CW = $clog2(PW);
  localparam logic [CW-1:0] PLL_LAST = CW'(PW - 1);
  localparam logic [CW-1:0] POST_LAST = CW'(W - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_PLL, S_HS, S_PB} st_t;
  st_t st;

  logic [W-1:0] m_q, d_q, p_q;
  logic [W-1:0] ref_t, core_t, hs_t;
  logic         pend;

  logic [PW-1:0] dv_q;
  logic [DW:0]   dv_r;
  logic [DW-1:0] dv_d;
  logic [CW-1:0] cnt;

  wire [W-1:0]  ref_c  = (m_q[2:1] == 2'b01) ? W'(REF_LO) : W'(REF_HI);
  wire          bypass = m_q[7] | ~m_q[3];
  wire [3:0]    mfi    = (p_q[13:10] < 4'd5) ? 4'd5 : p_q[13:10];
  wire [10:0]   mfd    = {1'b0, p_q[25:16]} + 11'd1;
  wire [4:0]    pd     = {1'b0, p_q[29:26]} + 5'd1;
  wire signed [17:0] mfn  = {{8{p_q[9]}}, p_q[9:0]};
  wire signed [17:0] term = $signed({4'b0, 14'(mfi * mfd)}) + mfn;
  wire          term_pos = (term > 18'sd0);
  wire [PW-1:0] num    = PW'(2) * PW'(ref_c >> 10) * PW'(term[16:0]);
  wire [DW-1:0] den    = DW'(mfd * pd);

  wire [DW:0]   rs   = {dv_r[DW-1:0], dv_q[PW-1]};
  wire          ge   = rs >= {1'b0, dv_d};
  wire [DW:0]   rn   = ge ? rs - {1'b0, dv_d} : rs;
  wire [PW-1:0] qn   = {dv_q[PW-2:0], ge};
  wire          last = (cnt == '0);

  wire [W-1:0]  pll_out = {qn[W-11:0], 10'b0};
  wire [DW-1:0] hs_div  = DW'(d_q[13:11]) + DW'(1);
  wire [DW-1:0] pb_div  = DW'(d_q[7:6]) + DW'(1);

  assign busy  = (st != S_IDLE);
  assign lf_hz = W'(LF_HZ);

  always_comb begin
    case (sel)
      3'd1:    sel_hz = core_hz;
      3'd2:    sel_hz = hs_hz;
      3'd3:    sel_hz = pb_hz;
      3'd4:    sel_hz = W'(LF_HZ);
      default: sel_hz = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pend    <= 1'b0;
      done    <= 1'b0;
      m_q     <= '0;
      d_q     <= '0;
      p_q     <= '0;
      ref_t   <= '0;
      core_t  <= '0;
      hs_t    <= '0;
      dv_q    <= '0;
      dv_r    <= '0;
      dv_d    <= '0;
      cnt     <= '0;
      ref_hz  <= '0;
      core_hz <= '0;
      hs_hz   <= '0;
      pb_hz   <= '0;
    end else begin
      done <= 1'b0;
      if (start && st != S_IDLE) pend <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          m_q <= mode_word;
          d_q <= div_word;
          p_q <= pll_word;
          st  <= S_LOAD;
        end
        S_LOAD: begin
          ref_t <= ref_c;
          dv_r  <= '0;
          if (bypass || !term_pos) begin
            core_t <= bypass ? ref_c : '0;
            dv_q   <= {bypass ? ref_c : W'(0), {(PW-W){1'b0}}};
            dv_d   <= hs_div;
            cnt    <= POST_LAST;
            st     <= S_HS;
          end else begin
            dv_q <= num;
            dv_d <= den;
            cnt  <= PLL_LAST;
            st   <= S_PLL;
          end
        end
        S_PLL, S_HS, S_PB: begin
          dv_q <= qn;
          dv_r <= rn;
          cnt  <= cnt - 1'b1;
          if (last) begin
            dv_r <= '0;
            cnt  <= POST_LAST;
            if (st == S_PLL) begin
              core_t <= pll_out;
              dv_q   <= {pll_out, {(PW-W){1'b0}}};
              dv_d   <= hs_div;
              st     <= S_HS;
            end else if (st == S_HS) begin
              hs_t <= qn[W-1:0];
              dv_q <= {qn[W-1:0], {(PW-W){1'b0}}};
              dv_d <= pb_div;
              st   <= S_PB;
            end else begin
              ref_hz  <= ref_t;
              core_hz <= core_t;
              hs_hz   <= hs_t;
              pb_hz   <= qn[W-1:0];
              done    <= 1'b1;
              if (pend || start) begin
                pend <= 1'b0;
                m_q  <= mode_word;
                d_q  <= div_word;
                p_q  <= pll_word;
                st   <= S_LOAD;
              end else begin
                st <= S_IDLE;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_hz != $past(core_hz) || hs_hz != $past(hs_hz) || pb_hz != $past(pb_hz)
     || ref_hz != $past(ref_hz)) |-> done); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R9
  AST_DIV_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pb_hz <= hs_hz && hs_hz <= core_hz)); // R7
  AST_REF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ref_hz == W'(REF_HI) || ref_hz == W'(REF_LO))); // R2
endmodule

// File: tb/sim_clkfreq_calc.sv
module sim_clkfreq_calc;
  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] mode_word = 0, div_word = 0, pll_word = 0;
  logic [2:0] sel = 0;
  logic busy, done;
  logic [31:0] ref_hz, core_hz, hs_hz, pb_hz, lf_hz, sel_hz;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  clkfreq_calc u0 (.clk(clk), .rst_n(rst_n), .start(start), .mode_word(mode_word),
    .div_word(div_word), .pll_word(pll_word), .sel(sel), .busy(busy), .done(done),
    .ref_hz(ref_hz), .core_hz(core_hz), .hs_hz(hs_hz), .pb_hz(pb_hz),
    .lf_hz(lf_hz), .sel_hz(sel_hz));

  task automatic chk(input string tag, input longint got, input longint exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic void model(input logic [31:0] m, dv, p,
                                output longint r, c, h, b);
    longint mfi, mfd, pd, mfn, term;
    r = (m[2:1] == 2'b01) ? 64'd33554432 : 64'd26000000;
    if (m[7] || !m[3]) c = r;
    else begin
      mfi = (p[13:10] < 5) ? 5 : longint'(p[13:10]);
      mfd = longint'(p[25:16]) + 1;
      pd  = longint'(p[29:26]) + 1;
      mfn = p[9] ? longint'(p[9:0]) - 1024 : longint'(p[9:0]);
      term = mfi * mfd + mfn;
      if (term <= 0) c = 0;
      else c = (((2 * (r >> 10) * term) / (mfd * pd)) << 10) & 64'hFFFFFFFF;
    end
    h = c / (1 + longint'(dv[13:11]));
    b = h / (1 + longint'(dv[7:6]));
  endfunction

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    if (!done) chk({tag, " timeout"}, 0, 1);
  endtask

  task automatic check_out(input string tag, input logic [31:0] m, dv, p);
    longint r, c, h, b;
    model(m, dv, p, r, c, h, b);
    chk({tag, " ref"}, ref_hz, r);
    chk({tag, " core"}, core_hz, c);
    chk({tag, " hs"}, hs_hz, h);
    chk({tag, " pb"}, pb_hz, b);
  endtask

  task automatic run_case(input string tag, input logic [31:0] m, dv, p);
    mode_word = m; div_word = dv; pll_word = p;
    pulse_start();
    chk({tag, " R8 busy"}, busy, 1);
    wait_done(tag);
    check_out(tag, m, dv, p);
    @(negedge clk);
    chk({tag, " R8 done width"}, done, 0);
    chk({tag, " R8 idle"}, busy, 0);
  endtask

  function automatic logic [31:0] pw(input int pdf, mfdf, mfif, mfnf);
    return {2'b0, 4'(pdf), 10'(mfdf), 2'b0, 4'(mfif), 10'(mfnf)};
  endfunction

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 ref", ref_hz, 0); chk("R1 core", core_hz, 0);
    chk("R1 hs", hs_hz, 0); chk("R1 pb", pb_hz, 0);
  endtask

  task automatic t_bypass();
    run_case("R3 bit3 clear R2 high ref R7", 32'h0, {18'b0, 3'd3, 3'b0, 2'd1, 6'b0}, pw(0,0,6,0));
    run_case("R3 bit7 set R2 low ref", 32'h0000_008A, {18'b0, 3'd7, 3'b0, 2'd3, 6'b0}, pw(0,0,6,0));
  endtask

  task automatic t_pll();
    run_case("R4 basic", 32'h0000_0008, {18'b0, 3'd1, 3'b0, 2'd0, 6'b0}, pw(0,0,6,0));
    run_case("R4 neg mfn", 32'h0000_0008, {18'b0, 3'd0, 3'b0, 2'd2, 6'b0}, pw(1,9,8,10'h3FD));
    run_case("R4 low ref", 32'h0000_000A, 32'h0, pw(3,4,12,1));
  endtask

  task automatic t_clamp();
    logic [31:0] c2;
    run_case("R5 mfi=2", 32'h8, 32'h0, pw(0,3,2,7));
    c2 = core_hz;
    run_case("R5 mfi=5", 32'h8, 32'h0, pw(0,3,5,7));
    chk("R5 same as 5", c2, core_hz);
  endtask

  task automatic t_nonpos();
    run_case("R6 negative term", 32'h8, {18'b0, 3'd2, 8'b0}, pw(0,0,5,10'h39C));
    chk("R6 core zero", core_hz, 0);
  endtask

  task automatic t_wrap();
    run_case("R11 wrap", 32'h0000_000A, {18'b0, 3'd1, 3'b0, 2'd1, 6'b0}, pw(0,0,15,511));
  endtask

  task automatic t_queue();
    logic [31:0] ma = 32'h0, da = 32'h0000_0840, pa = pw(0,0,6,0);
    logic [31:0] mb = 32'h8, db = 32'h0000_1000, pb = pw(1,9,8,3);
    longint r, c, h, b;
    int ndone = 0;
    mode_word = ma; div_word = da; pll_word = pa;
    pulse_start();
    repeat (5) @(negedge clk);
    mode_word = mb; div_word = db; pll_word = pb;
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    pulse_start();
    wait_done("R9 first");
    check_out("R9 first", ma, da, pa);
    model(ma, da, pa, r, c, h, b);
    repeat (10) @(negedge clk);
    chk("R8 hold while busy", core_hz, c);
    chk("R9 still busy", busy, 1);
    for (int i = 0; i < 600; i++) begin
      if (done) begin
        ndone++;
        if (ndone == 1) check_out("R9 second", mb, db, pb);
      end
      @(negedge clk);
    end
    chk("R9 one extra run", ndone, 1);
    chk("R9 idle after", busy, 0);
  endtask

  task automatic t_sel();
    run_case("R10 setup", 32'h8, {18'b0, 3'd2, 3'b0, 2'd1, 6'b0}, pw(0,1,7,0));
    sel = 0; #1 chk("R10 none", sel_hz, 0);
    sel = 1; #1 chk("R10 core", sel_hz, core_hz);
    sel = 2; #1 chk("R10 hs", sel_hz, hs_hz);
    sel = 3; #1 chk("R10 pb", sel_hz, pb_hz);
    sel = 4; #1 chk("R10 lf sel", sel_hz, 32768);
    sel = 6; #1 chk("R10 other", sel_hz, 0);
    chk("R10 lf", lf_hz, 32768);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_bypass();
    t_pll();
    t_clamp();
    t_nonpos();
    t_wrap();
    t_queue();
    t_sel();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule